// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits behind a three-channel video sampler. It takes one 8-bit sample per color channel on every pixel clock and spreads the samples over two output ports per channel, A and B. The ports can then run at a lower rate than the sampler. In single-port mode every pixel goes to port A and port B is disabled. In dual-port mode consecutive pixels alternate between the ports. Two output timings are available:

- **Interleaved:** each port is written on its own turn.
- **Parallel:** a pixel is held back until its partner arrives, and both ports are then written in the same cycle.

The alternation restarts at the leading edge of the line sync. The sync polarity is selectable. A swap control chooses which port takes the first pixel of a line. A data strobe marks each cycle in which the output word is complete. The strobe is high on every pixel in single-port mode and on every second pixel in dual-port mode.

Top module: `pxdemux`

## Requirements
- R1: While reset is asserted, and until the first output update after it, all six port buses read 0 and `porta_oe`, `portb_oe` and `data_stb` read 0. The first pixel taken after reset counts as the first pixel of a pair.
- R2: With `dual_en`=0, each pixel appears on port A. Port B keeps its previous value, and `portb_oe` is 0.
- R3: With `dual_en`=1 and `par_en`=0 (interleaved), each pixel is written to exactly one port, and the two ports take turns. A port that is not written keeps its previous value.
- R4: With `dual_en`=1 and `par_en`=1 (parallel), the first pixel of a pair changes no output. On the second pixel of the pair, both ports are written in the same cycle, one with each pixel of the pair.
- R5: The pixel presented in the cycle where the sync leading edge is seen is the first pixel of a new pair. An unmatched half pair that is left over from the previous line is dropped.
- R6: With `ab_swap`=0, the first pixel of a pair goes to port A. With `ab_swap`=1, it goes to port B.
- R7: With `sync_pol`=1, the leading edge is the 0-to-1 transition of `sync_in`. With `sync_pol`=0, it is the 1-to-0 transition. The opposite transition has no effect on the pairing.
- R8: In single-port mode, `data_stb` is 1 with every output update. In dual-port mode, `data_stb` is 1 only in the cycle after the second pixel of a pair has been written, so it is never high in two consecutive cycles.
- R9: A pixel presented before clock edge k, if it completes an output update, is visible on its port after edge k+1. This two-edge latency is the same in every mode.
- R10: The red, green and blue lanes always share the same routing and timing.
- R11: `porta_oe` goes to 1 with the first output update and stays at 1. `portb_oe` equals the `dual_en` value of the pixel whose update is on the ports, with the same latency as the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Line sync |
| sync_pol | input | 1 | 1: rising edge leads, 0: falling edge leads |
| dual_en | input | 1 | 1: dual-port mode |
| par_en | input | 1 | 1: parallel timing in dual-port mode |
| ab_swap | input | 1 | 1: first pixel of a pair goes to port B |
| samp_r | input | W | Red sample |
| samp_g | input | W | Green sample |
| samp_b | input | W | Blue sample |
| porta_r | output | W | Red port A |
| porta_g | output | W | Green port A |
| porta_b | output | W | Blue port A |
| portb_r | output | W | Red port B |
| portb_g | output | W | Green port B |
| portb_b | output | W | Blue port B |
| porta_oe | output | 1 | Port A output enable |
| portb_oe | output | 1 | Port B output enable |
| data_stb | output | 1 | Output word complete |

## Verification
The hardest case to reach is a sync edge that arrives in the middle of a pair in parallel timing. In that case the held pixel has to be dropped without any port moving. The stimulus runs lines with an odd pixel count in both dual-port timings, with and without swap, so that every new line begins with a half pair outstanding. The stimulus also changes the sync polarity so that the trailing transition lands where a false restart would show up.

// File: rtl/pxdemux_pkg.sv
package pxdemux_pkg;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HOLD = 1'b1
  } src_e;

  typedef struct packed {
    logic hold_en;
    logic wr_a;
    logic wr_b;
    src_e src_a;
    src_e src_b;
  } lane_ctl_t;

endpackage

// File: rtl/pxd_phase.sv
module pxd_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic sync_pol,
  output logic ph_cur
);

  logic act;
  logic act_q;
  logic ph_q;
  logic line_start;

  assign act        = sync_pol ? sync_in : ~sync_in;
  assign line_start = act & ~act_q;
  assign ph_cur     = line_start ? 1'b0 : ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b1;
    end else begin
      act_q <= act;
      ph_q  <= ph_cur;
    end
  end

endmodule

// File: rtl/pxd_ctrl.sv
module pxd_ctrl
  import pxdemux_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ph_cur,
  input  logic      dual_en,
  input  logic      par_en,
  input  logic      ab_swap,
  output lane_ctl_t ctl,
  output logic      porta_oe,
  output logic      portb_oe,
  output logic      data_stb
);

  logic s1_vld, s1_dual, s1_par, s1_ph, s1_dest;
  logic s1_dest_n;
  logic stb_n, oe_a_n, oe_b_n;
  logic oe_a_q, oe_b_q, stb_q;

  assign s1_dest_n = ph_cur ^ ab_swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_dual <= 1'b0;
      s1_par  <= 1'b0;
      s1_ph   <= 1'b0;
      s1_dest <= 1'b0;
    end else begin
      s1_vld  <= 1'b1;
      s1_dual <= dual_en;
      s1_par  <= par_en;
      s1_ph   <= ph_cur;
      s1_dest <= s1_dest_n;
    end
  end

  always_comb begin
    ctl   = '{hold_en: 1'b0, wr_a: 1'b0, wr_b: 1'b0, src_a: SRC_LIVE, src_b: SRC_LIVE};
    stb_n = 1'b0;
    if (s1_vld) begin
      if (!s1_dual) begin
        ctl.wr_a = 1'b1;
        stb_n    = 1'b1;
      end else if (!s1_par) begin
        ctl.wr_a = ~s1_dest;
        ctl.wr_b = s1_dest;
        stb_n    = s1_ph;
      end else if (!s1_ph) begin
        ctl.hold_en = 1'b1;
      end else begin
        ctl.wr_a  = 1'b1;
        ctl.wr_b  = 1'b1;
        ctl.src_a = s1_dest ? SRC_HOLD : SRC_LIVE;
        ctl.src_b = s1_dest ? SRC_LIVE : SRC_HOLD;
        stb_n     = 1'b1;
      end
    end
  end

  assign oe_a_n = s1_vld ? 1'b1    : oe_a_q;
  assign oe_b_n = s1_vld ? s1_dual : oe_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_a_q <= 1'b0;
      oe_b_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      oe_a_q <= oe_a_n;
      oe_b_q <= oe_b_n;
      stb_q  <= stb_n;
    end
  end

  assign porta_oe = oe_a_q;
  assign portb_oe = oe_b_q;
  assign data_stb = stb_q;

endmodule

// File: rtl/pxd_lane.sv
module pxd_lane
  import pxdemux_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] samp,
  input  lane_ctl_t    ctl,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b
);

  logic [W-1:0] s1_q, hold_q, a_q, b_q;
  logic [W-1:0] hold_n, a_n, b_n;

  always_comb begin
    hold_n = ctl.hold_en ? s1_q : hold_q;
    a_n    = a_q;
    b_n    = b_q;
    if (ctl.wr_a) a_n = (ctl.src_a == SRC_HOLD) ? hold_q : s1_q;
    if (ctl.wr_b) b_n = (ctl.src_b == SRC_HOLD) ? hold_q : s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      hold_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      s1_q   <= samp;
      hold_q <= hold_n;
      a_q    <= a_n;
      b_q    <= b_n;
    end
  end

  assign port_a = a_q;
  assign port_b = b_q;

endmodule

// File: rtl/pxdemux.sv
module pxdemux
  import pxdemux_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_in,
  input  logic         sync_pol,
  input  logic         dual_en,
  input  logic         par_en,
  input  logic         ab_swap,
  input  logic [W-1:0] samp_r,
  input  logic [W-1:0] samp_g,
  input  logic [W-1:0] samp_b,
  output logic [W-1:0] porta_r,
  output logic [W-1:0] porta_g,
  output logic [W-1:0] porta_b,
  output logic [W-1:0] portb_r,
  output logic [W-1:0] portb_g,
  output logic [W-1:0] portb_b,
  output logic         porta_oe,
  output logic         portb_oe,
  output logic         data_stb
);

  localparam int unsigned NCH = 3;

  logic           ph_cur;
  lane_ctl_t      ctl;
  logic [W-1:0]   samp_v [NCH];
  logic [W-1:0]   pa_v   [NCH];
  logic [W-1:0]   pb_v   [NCH];

  assign samp_v[0] = samp_r;
  assign samp_v[1] = samp_g;
  assign samp_v[2] = samp_b;

  pxd_phase i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .sync_pol (sync_pol),
    .ph_cur   (ph_cur)
  );

  pxd_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_cur   (ph_cur),
    .dual_en  (dual_en),
    .par_en   (par_en),
    .ab_swap  (ab_swap),
    .ctl      (ctl),
    .porta_oe (porta_oe),
    .portb_oe (portb_oe),
    .data_stb (data_stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    pxd_lane #(.W(W)) i_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp   (samp_v[c]),
      .ctl    (ctl),
      .port_a (pa_v[c]),
      .port_b (pb_v[c])
    );
  end

  assign porta_r = pa_v[0];
  assign porta_g = pa_v[1];
  assign porta_b = pa_v[2];
  assign portb_r = pb_v[0];
  assign portb_g = pb_v[1];
  assign portb_b = pb_v[2];

endmodule

// File: rtl/pxdemux_chk.sv
module pxdemux_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         par_en,
  input logic [W-1:0] porta_r,
  input logic [W-1:0] portb_r,
  input logic         porta_oe,
  input logic         portb_oe,
  input logic         data_stb
);

  AST_B_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !portb_oe |-> $stable(portb_r)); // R2

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    porta_oe && !portb_oe |-> data_stb); // R8

  AST_ILV_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    portb_oe && !$past(par_en, 2) |-> ($stable(porta_r) || $stable(portb_r))); // R3

  AST_PAR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    portb_oe && $past(par_en, 2) && !($stable(porta_r) && $stable(portb_r)) |-> data_stb); // R4

  AST_DUAL_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    portb_oe && $past(portb_oe) && data_stb |-> !$past(data_stb)); // R8

  AST_A_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    porta_oe |=> porta_oe); // R11

endmodule

bind pxdemux pxdemux_chk #(.W(W)) i_pxdemux_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .par_en   (par_en),
  .porta_r  (porta_r),
  .portb_r  (portb_r),
  .porta_oe (porta_oe),
  .portb_oe (portb_oe),
  .data_stb (data_stb)
);

// File: tb/test_pxdemux.sv
module test_pxdemux;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b1;
  logic       sync_pol = 1'b0;
  logic       dual_en = 1'b0;
  logic       par_en = 1'b0;
  logic       ab_swap = 1'b0;
  logic [7:0] samp_r = '0, samp_g = '0, samp_b = '0;
  logic [7:0] porta_r, porta_g, porta_b, portb_r, portb_g, portb_b;
  logic       porta_oe, portb_oe, data_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  pxdemux i_pxdemux (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_pol(sync_pol),
    .dual_en(dual_en), .par_en(par_en), .ab_swap(ab_swap),
    .samp_r(samp_r), .samp_g(samp_g), .samp_b(samp_b),
    .porta_r(porta_r), .porta_g(porta_g), .porta_b(porta_b),
    .portb_r(portb_r), .portb_g(portb_g), .portb_b(portb_b),
    .porta_oe(porta_oe), .portb_oe(portb_oe), .data_stb(data_stb)
  );

  // expected output word: {A rgb, B rgb, oe_a, oe_b, stb}
  typedef logic [50:0] exp_t;

  logic [23:0] m_a = '0, m_b = '0, m_hold = '0;
  logic        m_oa = 1'b0, m_ob = 1'b0, m_stb = 1'b0;
  logic        m_act = 1'b0, m_ph = 1'b1;
  exp_t        e1 = '0, e2 = '0;

  function automatic exp_t actual();
    return {porta_r, porta_g, porta_b, portb_r, portb_g, portb_b,
            porta_oe, portb_oe, data_stb};
  endfunction

  task automatic check(input exp_t exp, input string tag);
    n_chk++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, actual(), exp);
    end
  endtask

  // check outputs for pixel two steps back, drive new pixel, advance model
  task automatic step(input logic [7:0] v, input logic s, input string tag);
    logic [23:0] pix;
    logic act, ls, ph, dest;
    check(e2, tag);
    pix = {v, v ^ 8'h55, v + 8'h80};
    samp_r = pix[23:16]; samp_g = pix[15:8]; samp_b = pix[7:0];
    sync_in = s;
    act = sync_pol ? s : ~s;
    ls = act & ~m_act;
    m_act = act;
    ph = ls ? 1'b0 : ~m_ph;
    m_ph = ph;
    dest = ph ^ ab_swap;
    m_oa = 1'b1;
    m_ob = dual_en;
    if (!dual_en) begin
      m_a = pix; m_stb = 1'b1;
    end else if (!par_en) begin
      if (dest) m_b = pix; else m_a = pix;
      m_stb = ph;
    end else if (!ph) begin
      m_hold = pix; m_stb = 1'b0;
    end else begin
      if (dest) begin m_b = pix; m_a = m_hold; end
      else begin m_a = pix; m_b = m_hold; end
      m_stb = 1'b1;
    end
    e2 = e1;
    e1 = {m_a, m_b, m_oa, m_ob, m_stb};
    @(negedge clk);
  endtask

  task automatic run_line(input int npix, input logic [7:0] base, input string tag);
    for (int i = 0; i < npix; i++)
      step(base + 8'(i), (i < 2) ? sync_pol : ~sync_pol, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check('0, "R1 during reset");
    rst_n = 1'b1;
    step(8'h01, 1'b1, "R1 first");
    step(8'h02, 1'b1, "R1 second");
    step(8'h03, 1'b1, "R1/R9 first update");
  endtask

  task automatic t_single();
    dual_en = 1'b0; par_en = 1'b0; ab_swap = 1'b0;
    run_line(10, 8'h10, "R2/R8/R9/R10 single");
  endtask

  task automatic t_interleave();
    dual_en = 1'b1; par_en = 1'b0; ab_swap = 1'b0;
    run_line(12, 8'h30, "R3/R8/R10 interleaved");
    run_line(7, 8'h50, "R5 interleaved odd line");
    run_line(6, 8'h60, "R5 interleaved restart");
  endtask

  task automatic t_parallel();
    dual_en = 1'b1; par_en = 1'b1; ab_swap = 1'b0;
    run_line(12, 8'h70, "R4/R9 parallel");
    run_line(5, 8'h90, "R5 parallel odd line");
    run_line(8, 8'hA0, "R5 parallel dropped half pair");
  endtask

  task automatic t_swap();
    dual_en = 1'b1; ab_swap = 1'b1;
    par_en = 1'b0;
    run_line(9, 8'hB0, "R6 swapped interleaved");
    par_en = 1'b1;
    run_line(9, 8'hC0, "R6 swapped parallel");
    run_line(6, 8'hD0, "R6/R5 swapped parallel restart");
    ab_swap = 1'b0;
  endtask

  task automatic t_polarity();
    dual_en = 1'b1; par_en = 1'b0;
    sync_pol = 1'b1;
    step(8'hE0, 1'b0, "R7 polarity change");
    run_line(7, 8'hE1, "R7 rising edge leads");
    run_line(5, 8'hF0, "R7 trailing edge ignored");
    sync_pol = 1'b0;
    step(8'hF8, 1'b1, "R7 back to falling");
  endtask

  task automatic t_oe();
    dual_en = 1'b1; par_en = 1'b1;
    run_line(4, 8'h20, "R11 dual");
    dual_en = 1'b0;
    run_line(5, 8'h28, "R11/R2 back to single");
    for (int i = 0; i < 3; i++) step(8'h2F, 1'b1, "R11 flush");
  endtask

  initial begin
    t_reset();
    t_single();
    t_interleave();
    t_parallel();
    t_swap();
    t_polarity();
    t_oe();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule